// File: doc/BRIEF.md
# I/O Port Bus Cycle Generator

This block runs the processor side of a single I/O port access on a bus where I/O has its own request strobe, separate from memory requests. A request gives the instruction form, a read/write flag and the register values the address is built from. The block forms a full 16-bit port address, runs a fixed four-phase cycle, and returns read data with a one-clock completion pulse. The phases are address setup, strobe assertion, one automatic wait state, any number of externally requested wait states, and a final phase.

In the immediate form, the accumulator supplies the upper address byte and the immediate port number the lower byte. In the register-pair form, which the repeating block transfers also use, the B register supplies the upper byte and the C register the lower byte. A port decoder for attached peripherals is included. A parameter chooses whether it matches all 16 address bits, or matches only the low byte and passes the high byte to the peripheral as a sub-function code.

Top module: `io_bus_cycle`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `iorq_n`, `rd_n` and `wr_n` are 1, `done` and `data_oe` are 0, `req_ready` is 1, and `io_addr` and `rd_data` are 0.
- R2: When `req_form` is 0 (immediate), `io_addr` is {`acc`, `imm_port`}, with `acc` on bits 15:8.
- R3: When `req_form` is 1 (register pair, also used by block transfers), `io_addr` is {`reg_b`, `reg_c`}, with `reg_b` on bits 15:8. The full 16-bit address is held unchanged from T1 through T3.
- R4: In T1, `iorq_n`, `rd_n` and `wr_n` are all 1. From T2 through T3, `iorq_n` is 0 and exactly one of the two strobes is 0: `rd_n` when `req_write` is 0, and `wr_n` when `req_write` is 1.
- R5: Every cycle contains one automatic wait state after T2, so the strobes stay low for at least three clocks even with `wait_n` high. The `wait_n` value during T1 and T2 has no effect.
- R6: Each clock edge that ends a wait state with `wait_n` low adds one more wait state. The first edge with `wait_n` high moves the cycle to T3.
- R7: On a write, `data_oe` is 1 and `data_out` equals the captured write data from T1 through T3. On a read, `data_oe` stays 0.
- R8: On a read, `rd_data` captures `data_in` at the edge that ends the last wait state. Later changes of `data_in` do not alter it, and it holds until the next read completes.
- R9: `done` is 1 for exactly the T3 clock. `req_ready` is 1 only while idle, and a `req_valid` raised during a cycle is ignored.
- R10: With `FULL_DECODE` = 0, `port_sel[i]` is 1 while `iorq_n` is 0 and `io_addr[7:0]` equals `PORT_BASE[7:0]` + i. In this mode `sub_fn` equals `io_addr[15:8]`.
- R11: With `FULL_DECODE` = 1, `port_sel[i]` is 1 while `iorq_n` is 0 and `io_addr` equals `PORT_BASE` + i. In this mode `sub_fn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a cycle when idle |
| req_form | input | 1 | 0 immediate port, 1 register pair |
| req_write | input | 1 | 1 write, 0 read |
| acc | input | 8 | Accumulator value |
| imm_port | input | 8 | Immediate port number |
| reg_b | input | 8 | B register value |
| reg_c | input | 8 | C register value |
| wr_data | input | 8 | Data to write |
| wait_n | input | 1 | Active-low external wait |
| data_in | input | 8 | Data bus from peripherals |
| req_ready | output | 1 | Idle, request accepted |
| io_addr | output | 16 | Port address bus |
| iorq_n | output | 1 | Active-low I/O request |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| data_out | output | 8 | Data bus toward peripherals |
| data_oe | output | 1 | Data bus drive enable |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | Cycle completes this clock |
| port_sel | output | NUM_PORTS | Decoded peripheral selects |
| sub_fn | output | 8 | High address byte for sub-function use |

## Verification
The bench pulls `wait_n` low during T1 and T2. A design that sampled the external wait too early would stretch the cycle there, or would drop the automatic wait state when `wait_n` is high. It runs zero, one and several external waits, and changes `data_in` right after the capture edge. A read latched one clock late or early would return the wrong byte. It raises a second request during a busy cycle to catch a sequencer that restarts mid-cycle or corrupts the held address. It drives the same stimulus into one low-byte decoder and one full decoder. This exposes a decoder that ignores the high byte in full mode or uses it in low mode.

// File: rtl/io_cyc_pkg.sv
// Shared types for the I/O bus cycle generator.
// Assumes: one cycle in flight at a time.
package io_cyc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_TWX  = 3'd4,
        ST_T3   = 3'd5
    } io_state_t;

    typedef enum logic {
        FORM_IMM = 1'b0,
        FORM_REG = 1'b1
    } io_form_t;
endpackage

// File: rtl/io_addr_gen.sv
// Forms the 16-bit port address from the instruction form.
// Assumes: register pair form is also used by block transfers.
module io_addr_gen
    import io_cyc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              form,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] imm_port,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [DATA_W-1:0] reg_c,
    output logic [ADDR_W-1:0] addr
);
    // Select the high and low address bytes by form.
    always_comb begin
        if (io_form_t'(form) == FORM_REG) addr = {reg_b, reg_c};
        else                              addr = {acc, imm_port};
    end
endmodule

// File: rtl/io_seq.sv
// Cycle sequencer: T1, T2, automatic TW, external TW*, T3.
// Assumes: wait_n is synchronous to clk; strobes are active low.
module io_seq
    import io_cyc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              ready,
    output logic [ADDR_W-1:0] addr,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    io_state_t         state, state_nx;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q, rd_q;
    logic              active, in_cyc, last_wait;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_TW;
            ST_TW,
            ST_TWX:  state_nx = wait_n ? ST_T3 : ST_TWX;
            ST_T3:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // A wait state that ends now with wait_n high is the last one.
    assign last_wait = ((state == ST_TW) || (state == ST_TWX)) && wait_n;

    // State, request capture and read-data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                wr_q   <= wr_in;
                addr_q <= addr_in;
                wd_q   <= wdata_in;
            end
            if (last_wait && !wr_q) rd_q <= data_in;
        end
    end

    // Bus outputs decoded from the current phase.
    assign in_cyc   = (state != ST_IDLE);
    assign active   = (state == ST_T2) || (state == ST_TW) ||
                      (state == ST_TWX) || (state == ST_T3);
    assign iorq_n   = !active;
    assign rd_n     = !(active && !wr_q);
    assign wr_n     = !(active && wr_q);
    assign data_oe  = in_cyc && wr_q;
    assign data_out = wd_q;
    assign addr     = addr_q;
    assign rd_data  = rd_q;
    assign done     = (state == ST_T3);
    assign ready    = (state == ST_IDLE);

    assert_auto_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T2) |=> (state == ST_TW));
    assert_ext_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TW || state == ST_TWX) && !wait_n) |=> (state == ST_TWX));
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cyc && $past(state) != ST_IDLE) |-> $stable(addr_q));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T3) |=> $stable(rd_q));
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
endmodule

// File: rtl/io_port_dec.sv
// Port decoder for attached peripherals; FULL_DECODE picks 16-bit
// or low-byte match. Assumes selects are valid only while iorq_n is low.
module io_port_dec #(
    parameter int          DATA_W      = 8,
    parameter int          NUM_PORTS   = 4,
    parameter bit          FULL_DECODE = 1'b0,
    parameter logic [15:0] PORT_BASE   = 16'h12F0,
    localparam int         ADDR_W      = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 iorq_n,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic [DATA_W-1:0]    sub_fn
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        if (FULL_DECODE) begin : g_full
            // Whole address must match the port.
            assign port_sel[i] = !iorq_n && (addr == ADDR_W'(PORT_BASE + 16'(i)));
        end else begin : g_low
            // Only the low byte selects the port.
            assign port_sel[i] = !iorq_n &&
                (addr[DATA_W-1:0] == DATA_W'(PORT_BASE[DATA_W-1:0] + DATA_W'(i)));
        end
    end

    if (FULL_DECODE) begin : g_sub_full
        assign sub_fn = '0;
    end else begin : g_sub_low
        assign sub_fn = addr[ADDR_W-1:DATA_W];
    end

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));
    assert_sel_needs_iorq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iorq_n |-> (port_sel == '0));
endmodule

// File: rtl/io_bus_cycle.sv
// Top: I/O port bus cycle generator with address forming, sequencer
// and peripheral port decoder. Assumes requests are presented in idle.
module io_bus_cycle #(
    parameter int          DATA_W      = 8,
    parameter int          NUM_PORTS   = 4,
    parameter bit          FULL_DECODE = 1'b0,
    parameter logic [15:0] PORT_BASE   = 16'h12F0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_form,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    acc,
    input  logic [DATA_W-1:0]    imm_port,
    input  logic [DATA_W-1:0]    reg_b,
    input  logic [DATA_W-1:0]    reg_c,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 wait_n,
    input  logic [DATA_W-1:0]    data_in,
    output logic                 req_ready,
    output logic [2*DATA_W-1:0]  io_addr,
    output logic                 iorq_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    data_out,
    output logic                 data_oe,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic [DATA_W-1:0]    sub_fn
);
    localparam int ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] req_addr;

    io_addr_gen #(.DATA_W(DATA_W)) u_agen (
        .form(req_form), .acc(acc), .imm_port(imm_port),
        .reg_b(reg_b), .reg_c(reg_c), .addr(req_addr)
    );

    io_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .wr_in(req_write),
        .addr_in(req_addr), .wdata_in(wr_data), .wait_n(wait_n),
        .data_in(data_in), .ready(req_ready), .addr(io_addr),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .data_out(data_out),
        .data_oe(data_oe), .rd_data(rd_data), .done(done)
    );

    io_port_dec #(
        .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS),
        .FULL_DECODE(FULL_DECODE), .PORT_BASE(PORT_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(io_addr), .iorq_n(iorq_n),
        .port_sel(port_sel), .sub_fn(sub_fn)
    );
endmodule

// File: tb/sim_io_bus_cycle.sv
module sim_io_bus_cycle;
    localparam logic [15:0] BASE = 16'h12F0;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_form = 1'b0, req_write = 1'b0;
    logic [7:0] acc = '0, imm_port = '0, reg_b = '0, reg_c = '0, wr_data = '0;
    logic wait_n = 1'b1;
    logic [7:0] data_in = '0;

    logic req_ready, iorq_n, rd_n, wr_n, data_oe, done;
    logic [15:0] io_addr;
    logic [7:0] data_out, rd_data, sub_fn;
    logic [NP-1:0] port_sel;
    logic r1_ready, r1_iorq_n, r1_rd_n, r1_wr_n, r1_oe, r1_done;
    logic [15:0] r1_addr;
    logic [7:0] r1_dout, r1_rdata, f_sub;
    logic [NP-1:0] f_sel;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] last_rd = '0;

    always #2 clk = ~clk;

    io_bus_cycle #(.NUM_PORTS(NP), .FULL_DECODE(1'b0), .PORT_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
        .req_write(req_write), .acc(acc), .imm_port(imm_port), .reg_b(reg_b),
        .reg_c(reg_c), .wr_data(wr_data), .wait_n(wait_n), .data_in(data_in),
        .req_ready(req_ready), .io_addr(io_addr), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .data_out(data_out), .data_oe(data_oe), .rd_data(rd_data),
        .done(done), .port_sel(port_sel), .sub_fn(sub_fn)
    );

    io_bus_cycle #(.NUM_PORTS(NP), .FULL_DECODE(1'b1), .PORT_BASE(BASE)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
        .req_write(req_write), .acc(acc), .imm_port(imm_port), .reg_b(reg_b),
        .reg_c(reg_c), .wr_data(wr_data), .wait_n(wait_n), .data_in(data_in),
        .req_ready(r1_ready), .io_addr(r1_addr), .iorq_n(r1_iorq_n), .rd_n(r1_rd_n),
        .wr_n(r1_wr_n), .data_out(r1_dout), .data_oe(r1_oe), .rd_data(r1_rdata),
        .done(r1_done), .port_sel(f_sel), .sub_fn(f_sub)
    );

    function automatic logic [15:0] exp_addr(logic form, logic [7:0] a, i, b, c);
        return form ? {b, c} : {a, i};
    endfunction

    function automatic logic [NP-1:0] exp_low(logic [15:0] a, logic act);
        logic [NP-1:0] s = '0;
        for (int k = 0; k < NP; k++) s[k] = act && (a[7:0] == 8'(BASE[7:0] + k));
        return s;
    endfunction

    function automatic logic [NP-1:0] exp_full(logic [15:0] a, logic act);
        logic [NP-1:0] s = '0;
        for (int k = 0; k < NP; k++) s[k] = act && (a == 16'(BASE + k));
        return s;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_dec(logic [15:0] ea, logic act);
        chk("R10", "low sel", 32'(port_sel), 32'(exp_low(ea, act)));
        chk("R10", "low sub", 32'(sub_fn), 32'(ea[15:8]));
        chk("R11", "full sel", 32'(f_sel), 32'(exp_full(ea, act)));
        chk("R11", "full sub", 32'(f_sub), 32'h0);
    endtask

    // One complete cycle, starting and ending at a negedge in idle.
    task automatic run_cycle(logic form, logic wr, logic [7:0] a, i, b, c, wd,
                             int nwait, logic [7:0] rdv, bit poke);
        logic [15:0] ea = exp_addr(form, a, i, b, c);
        req_valid = 1'b1; req_form = form; req_write = wr;
        acc = a; imm_port = i; reg_b = b; reg_c = c; wr_data = wd; wait_n = 1'b1;
        @(negedge clk); // T1
        req_valid = poke;
        if (poke) begin
            req_form = ~form; req_write = ~wr; acc = ~a; imm_port = ~i;
            reg_b = ~b; reg_c = ~c; wr_data = ~wd;
        end
        chk(form ? "R3" : "R2", "T1 addr", 32'(io_addr), 32'(ea));
        chk("R4", "T1 strobes", {29'd0, iorq_n, rd_n, wr_n}, 32'h7);
        chk("R7", "T1 oe", 32'(data_oe), 32'(wr));
        if (wr) chk("R7", "T1 data", 32'(data_out), 32'(wd));
        chk("R9", "T1 ready", {30'd0, req_ready, done}, 32'h0);
        chk_dec(ea, 1'b0);
        wait_n = 1'b0; data_in = rdv;   // ignored before the auto wait ends
        @(negedge clk); // T2
        chk("R4", "T2 strobes", {29'd0, iorq_n, rd_n, wr_n}, {29'd0, 1'b0, wr, ~wr});
        chk("R3", "T2 addr", 32'(io_addr), 32'(ea));
        chk_dec(ea, 1'b1);
        @(negedge clk); // automatic TW
        chk("R5", "TW strobes", {29'd0, iorq_n, rd_n, wr_n}, {29'd0, 1'b0, wr, ~wr});
        chk("R5", "TW done", 32'(done), 32'h0);
        wait_n = (nwait == 0);
        for (int j = 0; j < nwait; j++) begin
            @(negedge clk); // external TW
            chk("R6", "TWX done", 32'(done), 32'h0);
            chk("R6", "TWX iorq", 32'(iorq_n), 32'h0);
            wait_n = (j + 1 >= nwait);
        end
        @(negedge clk); // T3
        chk("R9", "T3 done", 32'(done), 32'h1);
        chk("R4", "T3 strobes", {29'd0, iorq_n, rd_n, wr_n}, {29'd0, 1'b0, wr, ~wr});
        chk("R3", "T3 addr", 32'(io_addr), 32'(ea));
        chk("R7", "T3 oe", 32'(data_oe), 32'(wr));
        if (wr) chk("R7", "T3 data", 32'(data_out), 32'(wd));
        if (!wr) last_rd = rdv;
        chk("R8", "T3 rd_data", 32'(rd_data), 32'(last_rd));
        chk_dec(ea, 1'b1);
        data_in = ~rdv; req_valid = 1'b0; wait_n = 1'b1;
        @(negedge clk); // idle
        chk("R9", "idle done/ready", {30'd0, req_ready, done}, 32'h2);
        chk("R4", "idle strobes", {29'd0, iorq_n, rd_n, wr_n}, 32'h7);
        chk("R8", "idle rd_data", 32'(rd_data), 32'(last_rd));
        chk("R7", "idle oe", 32'(data_oe), 32'h0);
        @(negedge clk); // still idle: poke must not have started a cycle
        chk("R9", "no restart", {30'd0, req_ready, iorq_n}, 32'h3);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "strobes", {29'd0, iorq_n, rd_n, wr_n}, 32'h7);
        chk("R1", "done/oe/ready", {29'd0, done, data_oe, req_ready}, 32'h1);
        chk("R1", "addr", 32'(io_addr), 32'h0);
        chk("R1", "rd_data", 32'(rd_data), 32'h0);

        // Directed corners
        run_cycle(1'b0, 1'b0, 8'h12, 8'hF1, 8'h00, 8'h00, 8'h00, 0, 8'hA5, 1'b0); // R2 read
        run_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'h12, 8'hF3, 8'h3C, 0, 8'h00, 1'b0); // R3 write
        run_cycle(1'b1, 1'b0, 8'h77, 8'h00, 8'hAB, 8'hF2, 8'h00, 1, 8'h5A, 1'b0); // R6 one wait
        run_cycle(1'b0, 1'b1, 8'h34, 8'hF0, 8'h00, 8'h00, 8'hC3, 4, 8'h00, 1'b1); // R9 poke
        run_cycle(1'b0, 1'b0, 8'hFF, 8'h10, 8'h00, 8'h00, 8'h00, 3, 8'h81, 1'b1); // R8 read
        run_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'h12, 8'hF4, 8'h99, 2, 8'h00, 1'b0); // just past range

        // Random
        for (int n = 0; n < 60; n++) begin
            logic [7:0] ra = ($urandom % 2) ? 8'h12 : 8'($urandom);
            logic [7:0] rl = ($urandom % 2) ? 8'(8'hF0 + $urandom % 6) : 8'($urandom);
            run_cycle(1'($urandom), 1'($urandom), ra, rl, ra, rl, 8'($urandom),
                      int'($urandom % 4), 8'($urandom), 1'($urandom));
        end

        // R1 reset in the middle of an external wait
        req_valid = 1'b1; req_form = 1'b1; req_write = 1'b0; reg_b = 8'h55; reg_c = 8'h66;
        @(negedge clk); req_valid = 1'b0; wait_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R6", "held in TWX", 32'(iorq_n), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset strobes", {29'd0, iorq_n, rd_n, wr_n}, 32'h7);
        chk("R1", "mid reset state", {29'd0, done, data_oe, req_ready}, 32'h1);
        chk("R1", "mid reset addr/rd", {8'd0, io_addr, rd_data}, 32'h0);
        rst_n = 1'b1; wait_n = 1'b1; last_rd = '0;
        @(negedge clk);
        run_cycle(1'b1, 1'b0, 8'h00, 8'h00, 8'h12, 8'hF0, 8'h00, 0, 8'h42, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule